// File: doc/BRIEF.md
# Slot-Gated Video Write Queue

This block sits between a processor and the memories of a video generator. The processor writes to either the pattern/name video memory or the palette (colour) memory. The writes do not reach the memory at once. They wait in a small first-in first-out queue and leave it only at fixed access points on the scanline. There is a regular access point every sixteen pixels, which is every two 8-pixel cells, counted from the left edge of the line. There is also one extra access point at the pixel where the horizontal interrupt fires. This keeps memory updates aligned to the boundaries at which the renderer fetches its data.

When the queue holds its full four entries, the block raises a stall flag. The processor must hold its write until the flag drops. A write presented in a cycle where the queue both is full and gives up an entry is taken.

A palette write that commits while a line is being rasterized also overrides the colour of the pixel being output in that same cycle. This covers border and blanked-display pixels as well as active ones. The override lasts exactly one pixel. The downstream colour path uses it to show the written colour in place of its normal lookup.

Top module: `vid_slot_wfifo`

## Requirements
- R1: Stored writes commit only in cycles where `pixelCount` mod 16 equals 0 or `pixelCount` equals the interrupt position `HINT_POS`. No strobe is raised in any other cycle.
- R2: With the default `HINT_POS` of 312, which is not a multiple of 16, a pending entry commits in the cycle where `pixelCount` is 312.
- R3: At most one entry commits per access point, and entries commit in the order they were accepted.
- R4: `fifoFull` is high exactly when four entries are held. A write presented while full in a cycle without a commit is discarded and never reaches memory.
- R5: A write presented while full in a cycle where an entry commits is accepted, so the queue stays full.
- R6: A committing entry with `wrTarget`=0 (video memory) raises `vramWe`. One with `wrTarget`=1 (palette) raises `cramWe`. The strobe comes in the access-point cycle itself, with `memAddr`/`memData` carrying the entry's address and data. The two strobes are never high together.
- R7: A palette commit while `lineActive` is high raises `ovrValid` for that single cycle, with `ovrColor` equal to the committed data.
- R8: A palette commit while `lineActive` is low still writes the palette but leaves `ovrValid` low.
- R9: Reset empties the queue: `fifoFull` low and no strobes, even at an access point. Entries accepted before reset never commit.
- R10: Access points keep draining the queue while `lineActive` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixelCount | input | 9 | Horizontal pixel position on the current line |
| lineActive | input | 1 | High while the line is being rasterized (border included) |
| wrValid | input | 1 | Processor write request |
| wrTarget | input | 1 | 0 = video memory, 1 = palette memory |
| wrAddr | input | 16 | Write address |
| wrData | input | 16 | Write data |
| fifoFull | output | 1 | Queue holds four entries; processor must stall |
| vramWe | output | 1 | Video memory write strobe |
| cramWe | output | 1 | Palette memory write strobe |
| memAddr | output | 16 | Address of the committing entry |
| memData | output | 16 | Data of the committing entry |
| ovrValid | output | 1 | Override the current pixel's colour |
| ovrColor | output | 16 | Colour to show when `ovrValid` is high |

## Verification
The queue is filled with a mix of video and palette writes. It is then stepped through a line that includes positions just off an access point, regular access points, and the interrupt position. This separates correct slot gating from draining on any cycle, and shows that commit order follows acceptance order. Writes presented while full, with and without a simultaneous commit, tell a correct stall apart from both overwriting and refusing legal writes. A palette commit is tried once with `lineActive` high and once low, which separates the override gating from the memory strobe. A reset with entries pending shows that stale data is flushed.

// File: rtl/vsw_pkg.sv
package vsw_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int CELL_PIXELS = 8;
  localparam int CELLS_PER_SLOT = 2;

  typedef enum logic {
    TGT_VRAM = 1'b0,
    TGT_CRAM = 1'b1
  } target_e;

  typedef struct packed {
    target_e            target;
    logic [ADDR_W-1:0]  addr;
    logic [DATA_W-1:0]  data;
  } entry_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic push;
    logic pop;
  } ctl_t;
endpackage

// File: rtl/vsw_ctrl.sv
module vsw_ctrl
  import vsw_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int PIX_W    = 9,
  parameter int HINT_POS = 312,
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PIX_W-1:0] pixelCount,
  input  logic             wrValid,
  output ctl_t             ctl,
  output logic [PTR_W-1:0] wrIdx,
  output logic [PTR_W-1:0] rdIdx,
  output logic             fifoFull
);
  localparam int SLOT_SPAN  = CELL_PIXELS * CELLS_PER_SLOT;
  localparam int SLOT_SHIFT = $clog2(SLOT_SPAN);
  localparam logic [PIX_W-1:0] HINT_PIX = PIX_W'(HINT_POS);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] count;
  logic regularSlot;
  logic extraSlot;
  logic slotHit;
  logic isEmpty;

  assign regularSlot = (pixelCount[SLOT_SHIFT-1:0] == '0);

  generate
    if ((HINT_POS % SLOT_SPAN) == 0) begin : g_hint_merged
      assign extraSlot = 1'b0;
    end else begin : g_hint_extra
      assign extraSlot = (pixelCount == HINT_PIX);
    end
  endgenerate

  assign slotHit  = regularSlot | extraSlot;
  assign isEmpty  = (count == '0);
  assign fifoFull = (count == FULL_CNT);

  always_comb begin
    ctl.pop  = slotHit && !isEmpty;
    ctl.push = wrValid && (!fifoFull || ctl.pop);
  end

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      wrIdx <= '0;
      rdIdx <= '0;
    end else begin
      if (ctl.push) wrIdx <= nextPtr(wrIdx);
      if (ctl.pop)  rdIdx <= nextPtr(rdIdx);
      case ({ctl.push, ctl.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/vsw_data.sv
module vsw_data
  import vsw_pkg::*;
#(
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  ctl_t              ctl,
  input  logic [PTR_W-1:0]  wrIdx,
  input  logic [PTR_W-1:0]  rdIdx,
  input  logic              lineActive,
  input  logic              wrTarget,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              vramWe,
  output logic              cramWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              ovrValid,
  output logic [DATA_W-1:0] ovrColor
);
  entry_t store [DEPTH];
  entry_t head;

  always_ff @(posedge clk) begin
    if (ctl.push) begin
      store[wrIdx] <= '{target: target_e'(wrTarget), addr: wrAddr, data: wrData};
    end
  end

  assign head = store[rdIdx];

  always_comb begin
    vramWe   = ctl.pop && (head.target == TGT_VRAM);
    cramWe   = ctl.pop && (head.target == TGT_CRAM);
    memAddr  = head.addr;
    memData  = head.data;
    ovrValid = cramWe && lineActive;
    ovrColor = head.data;
  end
endmodule

// File: rtl/vid_slot_wfifo.sv
module vid_slot_wfifo
  import vsw_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int LINE_PIXELS = 320,
  parameter int HINT_POS    = 312,
  localparam int PIX_W      = $clog2(LINE_PIXELS),
  localparam int PTR_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PIX_W-1:0]  pixelCount,
  input  logic              lineActive,
  input  logic              wrValid,
  input  logic              wrTarget,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              fifoFull,
  output logic              vramWe,
  output logic              cramWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              ovrValid,
  output logic [DATA_W-1:0] ovrColor
);
  ctl_t             ctl;
  logic [PTR_W-1:0] wrIdx;
  logic [PTR_W-1:0] rdIdx;

  vsw_ctrl #(.DEPTH(DEPTH), .PIX_W(PIX_W), .HINT_POS(HINT_POS)) u_ctrl (
    .clk(clk), .rstN(rstN), .pixelCount(pixelCount), .wrValid(wrValid),
    .ctl(ctl), .wrIdx(wrIdx), .rdIdx(rdIdx), .fifoFull(fifoFull)
  );

  vsw_data #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .ctl(ctl), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .lineActive(lineActive), .wrTarget(wrTarget), .wrAddr(wrAddr), .wrData(wrData),
    .vramWe(vramWe), .cramWe(cramWe), .memAddr(memAddr), .memData(memData),
    .ovrValid(ovrValid), .ovrColor(ovrColor)
  );
endmodule

// File: rtl/vsw_checker.sv
module vsw_checker #(
  parameter int LINE_PIXELS = 320,
  parameter int HINT_POS    = 312,
  localparam int PIX_W      = $clog2(LINE_PIXELS)
) (
  input logic             clk,
  input logic             rstN,
  input logic [PIX_W-1:0] pixelCount,
  input logic             lineActive,
  input logic             wrValid,
  input logic             fifoFull,
  input logic             vramWe,
  input logic             cramWe,
  input logic [15:0]      memData,
  input logic             ovrValid,
  input logic [15:0]      ovrColor
);
  localparam logic [PIX_W-1:0] HINT_PIX = PIX_W'(HINT_POS);
  logic commit;
  assign commit = vramWe || cramWe;

  assert_slot_only_R1: assert property (@(posedge clk) disable iff (!rstN)
    commit |-> (pixelCount[3:0] == 4'd0 || pixelCount == HINT_PIX));

  assert_one_drain_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && commit && !wrValid) |=> !fifoFull);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && wrValid && !commit) |=> fifoFull);

  assert_refill_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && wrValid && commit) |=> fifoFull);

  assert_one_target_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(vramWe && cramWe));

  assert_override_R7: assert property (@(posedge clk) disable iff (!rstN)
    ovrValid |-> (cramWe && lineActive && ovrColor == memData));

  assert_no_override_R8: assert property (@(posedge clk) disable iff (!rstN)
    !lineActive |-> !ovrValid);
endmodule

bind vid_slot_wfifo vsw_checker #(.LINE_PIXELS(LINE_PIXELS), .HINT_POS(HINT_POS)) u_chk (
  .clk(clk), .rstN(rstN), .pixelCount(pixelCount), .lineActive(lineActive),
  .wrValid(wrValid), .fifoFull(fifoFull), .vramWe(vramWe), .cramWe(cramWe),
  .memData(memData), .ovrValid(ovrValid), .ovrColor(ovrColor)
);

// File: tb/vid_slot_wfifo_tb.sv
`timescale 1ns/1ps
module vid_slot_wfifo_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [8:0]  pixelCount = '0;
  logic        lineActive = 1'b0;
  logic        wrValid = 1'b0;
  logic        wrTarget = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        fifoFull, vramWe, cramWe, ovrValid;
  logic [15:0] memAddr, memData, ovrColor;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  vid_slot_wfifo u_dut (
    .clk(clk), .rstN(rstN), .pixelCount(pixelCount), .lineActive(lineActive),
    .wrValid(wrValid), .wrTarget(wrTarget), .wrAddr(wrAddr), .wrData(wrData),
    .fifoFull(fifoFull), .vramWe(vramWe), .cramWe(cramWe), .memAddr(memAddr),
    .memData(memData), .ovrValid(ovrValid), .ovrColor(ovrColor)
  );

  typedef struct packed {
    logic [8:0]  pix;
    logic        la, wv, tgt;
    logic [15:0] addr, data;
    logic        eV, eC, eO, eF;
    logic [15:0] eA, eD;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t VEC [NVEC] = '{
    '{9'd1,   1,1,0,16'h0010,16'h1111, 0,0,0,0,16'h0000,16'h0000, 4'd1}, // R1 off-slot
    '{9'd2,   1,1,1,16'h0002,16'h0ABC, 0,0,0,0,16'h0000,16'h0000, 4'd1}, // R1
    '{9'd3,   1,1,0,16'h0020,16'h2222, 0,0,0,0,16'h0000,16'h0000, 4'd1}, // R1
    '{9'd4,   1,1,0,16'h0030,16'h3333, 0,0,0,0,16'h0000,16'h0000, 4'd1}, // R1
    '{9'd5,   1,1,0,16'h0099,16'h9999, 0,0,0,1,16'h0000,16'h0000, 4'd4}, // R4 full, dropped
    '{9'd16,  1,1,0,16'h0040,16'h4444, 1,0,0,1,16'h0010,16'h1111, 4'd5}, // R5 write with drain
    '{9'd17,  1,1,0,16'h0098,16'h9898, 0,0,0,1,16'h0000,16'h0000, 4'd4}, // R4 dropped
    '{9'd32,  1,0,0,16'h0000,16'h0000, 0,1,1,1,16'h0002,16'h0ABC, 4'd7}, // R7 override
    '{9'd33,  1,0,0,16'h0000,16'h0000, 0,0,0,0,16'h0000,16'h0000, 4'd3}, // R3 one per slot
    '{9'd40,  1,0,0,16'h0000,16'h0000, 0,0,0,0,16'h0000,16'h0000, 4'd1}, // R1 mid-span
    '{9'd48,  0,0,0,16'h0000,16'h0000, 1,0,0,0,16'h0020,16'h2222, 4'd10},// R10 blank drain
    '{9'd312, 1,0,0,16'h0000,16'h0000, 1,0,0,0,16'h0030,16'h3333, 4'd2}, // R2 hint slot
    '{9'd313, 1,0,0,16'h0000,16'h0000, 0,0,0,0,16'h0000,16'h0000, 4'd3}, // R3
    '{9'd64,  1,0,0,16'h0000,16'h0000, 1,0,0,0,16'h0040,16'h4444, 4'd3}, // R3 order
    '{9'd80,  1,0,0,16'h0000,16'h0000, 0,0,0,0,16'h0000,16'h0000, 4'd4}, // R4 dropped never drain
    '{9'd81,  0,1,1,16'h0003,16'h0111, 0,0,0,0,16'h0000,16'h0000, 4'd1}, // R1
    '{9'd96,  0,0,0,16'h0000,16'h0000, 0,1,0,0,16'h0003,16'h0111, 4'd8}, // R8 no override
    '{9'd97,  1,1,0,16'h0050,16'h5555, 0,0,0,0,16'h0000,16'h0000, 4'd1}, // R1
    '{9'd112, 1,1,0,16'h0060,16'h6666, 1,0,0,0,16'h0050,16'h5555, 4'd6}, // R6 vram target
    '{9'd128, 1,0,0,16'h0000,16'h0000, 1,0,0,0,16'h0060,16'h6666, 4'd6}  // R6
  };

  task automatic drive(input logic [8:0] pix, input logic la, input logic wv,
                       input logic tgt, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    pixelCount = pix; lineActive = la; wrValid = wv;
    wrTarget = tgt; wrAddr = a; wrData = d;
    #1;
  endtask

  task automatic expect_out(input string req, input logic eV, input logic eC,
                            input logic eO, input logic eF,
                            input logic [15:0] eA, input logic [15:0] eD);
    logic ok;
    ok = (vramWe == eV) && (cramWe == eC) && (ovrValid == eO) && (fifoFull == eF);
    if ((eV || eC) && (memAddr != eA || memData != eD)) ok = 1'b0;
    if (eO && ovrColor != eD) ok = 1'b0;
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s pix=%0d: got v=%b c=%b o=%b f=%b a=%h d=%h oc=%h exp v=%b c=%b o=%b f=%b a=%h d=%h",
               req, pixelCount, vramWe, cramWe, ovrValid, fifoFull, memAddr, memData,
               ovrColor, eV, eC, eO, eF, eA, eD);
    end
  endtask

  initial begin : watchdog
    while (!finished && cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hang, exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    // R9: reset state at an access point with reset held
    drive(9'd0, 1'b1, 1'b0, 1'b0, 16'h0, 16'h0);
    expect_out("R9", 0, 0, 0, 0, 16'h0, 16'h0);
    drive(9'd0, 1'b1, 1'b0, 1'b0, 16'h0, 16'h0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i].pix, VEC[i].la, VEC[i].wv, VEC[i].tgt, VEC[i].addr, VEC[i].data);
      expect_out($sformatf("R%0d", VEC[i].req), VEC[i].eV, VEC[i].eC, VEC[i].eO,
                 VEC[i].eF, VEC[i].eA, VEC[i].eD);
    end

    // R9: pending entries are flushed by reset
    drive(9'd129, 1'b1, 1'b1, 1'b0, 16'h0070, 16'h7777);
    drive(9'd130, 1'b1, 1'b1, 1'b1, 16'h0071, 16'h7171);
    drive(9'd131, 1'b1, 1'b0, 1'b0, 16'h0, 16'h0);
    rstN = 1'b0;
    drive(9'd132, 1'b1, 1'b0, 1'b0, 16'h0, 16'h0);
    rstN = 1'b1;
    drive(9'd144, 1'b1, 1'b0, 1'b0, 16'h0, 16'h0);
    expect_out("R9", 0, 0, 0, 0, 16'h0, 16'h0);
    drive(9'd160, 1'b1, 1'b0, 1'b0, 16'h0, 16'h0);
    expect_out("R9", 0, 0, 0, 0, 16'h0, 16'h0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule